// File: doc/BRIEF.md
# Run-Mode Clock Configuration Register Slice

This block is a small memory-mapped slice of a system-control register space. It holds two run-mode clock configuration words. The base word is always present. The extended word takes over the divider selection when its top bit is set. A static device identification word tells the block which device generation it sits in. On the older generation the extended word is frozen at zero and ignores writes.

The block keeps a registered system clock scale, equal to five times one plus the active divider field. It serves a read-only PLL configuration word, looked up from one of two 16-entry tables by the crystal field of the base word. It also keeps one raw interrupt status flag. This flag is raised when software powers the PLL on through the extended word, and software clears it by writing a one to it.

Access is a single-cycle bus: a word offset, write data and a write strobe, with combinational read data.

Top module: `clk_ctl_regs`

## Requirements
- R1: Out of reset the base word reads 0x078E3AC0 and the status word reads 0. The extended word reads 0 on the older generation and 0x07802810 otherwise. The scale output is 80.
- R2: The generation is decoded from version = id[30:28] and class = id[23:16]. Version 0 is older whatever the class. Version 1 with class 0 is older. Version 1 with class 1 is newer. Any other combination is neither, which behaves as newer for writes and reset but uses the older PLL table.
- R3: On the older generation a write to the extended word (word offset 0x1C) leaves it at 0.
- R4: On any other generation the extended word reads back the last value written to it.
- R5: The base word (word offset 0x18) reads back the last value written to it.
- R6: When extended bit 31 is 1, the divider is extended bits [28:23]; otherwise it is base bits [26:23]. The scale output equals 5*(divider+1) and follows a register change one clock later. It stays stable while both words are unchanged.
- R7: An accepted extended write whose stored bit 13 is 1 and whose new bit 13 is 0 sets status bit 6. The status word is at word offset 0x14, and its other bits read 0.
- R8: Writing the status word with bit 6 set clears the flag. Writing it with bit 6 clear leaves the flag unchanged.
- R9: The PLL configuration word (word offset 0x19) returns entry base[9:6] of the newer table on the newer generation, and of the older table otherwise. Writes to it have no effect.
- R10: Reads of every other offset return 0, and writes to them change no register.
- R11: An ignored extended write on the older generation never sets the status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id_i | input | 32 | Static device identification word |
| off_i | input | OFF_W (6) | Word offset of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for off_i |
| scale_o | output | SCALE_W (9) | Registered system clock scale |

## Verification
Several properties are checked on every cycle. The extended word is held at zero on the older generation. The flag rises only after an extended write and is set by a PLL power-on edge. It is cleared by a write-one, and unmapped offsets read zero. The scale stays put while both clock words are stable and is always a non-zero multiple of five. Only the bench's scenarios, run across five device identities, can show the exact reset values, the 6-bit versus 4-bit divider selection and its one-cycle lag, the table chosen per generation, and the fact that unmapped or read-only writes disturb nothing.

// File: rtl/clk_ctl_pkg.sv
`timescale 1ns/1ps
package clk_ctl_pkg;
   typedef enum logic [1:0] {
      DEV_OLDER = 2'd0,
      DEV_NEWER = 2'd1,
      DEV_OTHER = 2'd2
   } dev_gen_e;

   // version field and class field of the identification word
   function automatic dev_gen_e classify(input logic [2:0] ver, input logic [7:0] cls);
      dev_gen_e g;
      case (ver)
         3'd0:    g = DEV_OLDER;
         3'd1:    g = (cls == 8'd0) ? DEV_OLDER :
                      (cls == 8'd1) ? DEV_NEWER : DEV_OTHER;
         default: g = DEV_OTHER;
      endcase
      return g;
   endfunction
endpackage

// File: rtl/clk_ctl_devdec.sv
`timescale 1ns/1ps
module clk_ctl_devdec
   import clk_ctl_pkg::*;
(
   input  logic [2:0] ver_i,
   input  logic [7:0] cls_i,
   output dev_gen_e   gen_o
);
   assign gen_o = classify(ver_i, cls_i);
endmodule

// File: rtl/clk_ctl_pll_rom.sv
`timescale 1ns/1ps
module clk_ctl_pll_rom #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4,
   localparam int DEPTH = 1 << IDX_W,
   parameter logic [DATA_W-1:0] TAB_OLD [DEPTH] = '{default: '0},
   parameter logic [DATA_W-1:0] TAB_NEW [DEPTH] = '{default: '0}
) (
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              use_new_i,
   output logic [DATA_W-1:0] data_o
);
   logic [DATA_W-1:0] sel [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign sel[i] = use_new_i ? TAB_NEW[i] : TAB_OLD[i];
   end

   assign data_o = sel[idx_i];
endmodule

// File: rtl/clk_ctl_scale.sv
`timescale 1ns/1ps
module clk_ctl_scale #(
   parameter int PRI_W     = 4,
   parameter int EXT_W     = 6,
   parameter int OUT_W     = 9,
   parameter int MULT      = 5,
   parameter int RST_SCALE = 80
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             use_ext_i,
   input  logic [PRI_W-1:0] pri_div_i,
   input  logic [EXT_W-1:0] ext_div_i,
   output logic [OUT_W-1:0] scale_o
);
   localparam int MAX_SCALE = MULT * (1 << EXT_W);

   if (EXT_W < PRI_W) begin : g_bad_w
      $error("extended divider narrower than base divider");
   end
   if (OUT_W < $clog2(MAX_SCALE + 1)) begin : g_bad_out
      $error("scale output too narrow");
   end

   logic [EXT_W-1:0] div;
   logic [OUT_W-1:0] scale_d;

   always_comb begin
      div     = use_ext_i ? ext_div_i : EXT_W'(pri_div_i);
      scale_d = OUT_W'(MULT * (int'(div) + 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scale_o <= OUT_W'(RST_SCALE);
      else        scale_o <= scale_d;
   end

   // R6: the scale is always a non-zero multiple of the multiplier
   p_scale_mult_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(scale_o) % MULT == 0) && (int'(scale_o) >= MULT));
endmodule

// File: rtl/clk_ctl_regs.sv
`timescale 1ns/1ps
module clk_ctl_regs
   import clk_ctl_pkg::*;
#(
   parameter int          OFF_W       = 6,
   parameter int          DATA_W      = 32,
   parameter int          SCALE_W     = 9,
   parameter int          SCALE_MULT  = 5,
   parameter logic [5:0]  OFF_STS     = 6'h14,
   parameter logic [5:0]  OFF_BASE    = 6'h18,
   parameter logic [5:0]  OFF_PLL     = 6'h19,
   parameter logic [5:0]  OFF_EXT     = 6'h1C,
   parameter logic [31:0] BASE_RST    = 32'h078E3AC0,
   parameter logic [31:0] EXT_RST     = 32'h07802810,
   parameter int          DIV_LSB     = 23,
   parameter int          BASE_DIV_W  = 4,
   parameter int          EXT_DIV_W   = 6,
   parameter int          XTAL_LSB    = 6,
   parameter int          XTAL_W      = 4,
   parameter int          SEL_EXT_BIT = 31,
   parameter int          PLL_PD_BIT  = 13,
   parameter int          IRQ_BIT     = 6,
   parameter logic [31:0] PLL_OLD [16] = '{
      32'h0, 32'h0, 32'h0, 32'h0,
      32'h0000_A280, 32'h0000_A2C0, 32'h0000_A330, 32'h0000_A380,
      32'h0000_A3E0, 32'h0000_A430, 32'h0000_A4A0, 32'h0000_A500,
      32'h0000_A560, 32'h0000_A5D0, 32'h0000_A640, 32'h0000_A6A0},
   parameter logic [31:0] PLL_NEW [16] = '{
      32'h0000_1301, 32'h0000_1342, 32'h0000_1383, 32'h0000_13C4,
      32'h0000_1405, 32'h0000_1446, 32'h0000_1487, 32'h0000_14C8,
      32'h0000_1509, 32'h0000_154A, 32'h0000_158B, 32'h0000_15CC,
      32'h0000_160D, 32'h0000_164E, 32'h0000_168F, 32'h0000_16D0}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [31:0]        dev_id_i,
   input  logic [OFF_W-1:0]   off_i,
   input  logic               wr_en_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic [SCALE_W-1:0] scale_o
);
   localparam int RST_SCALE =
      SCALE_MULT * (int'(BASE_RST[DIV_LSB+BASE_DIV_W-1:DIV_LSB]) + 1);

   if (DATA_W != 32) begin : g_bad_data
      $error("register slice is defined for 32-bit words");
   end
   if (OFF_W < 6) begin : g_bad_off
      $error("offset too narrow for the register map");
   end
   if (EXT_RST[SEL_EXT_BIT]) begin : g_bad_rst
      $error("extended reset value must not select the extended divider");
   end
   if (XTAL_W != 4) begin : g_bad_xtal
      $error("PLL tables hold 16 entries");
   end

   dev_gen_e gen;
   logic [DATA_W-1:0] base_q, ext_q, pll_word;
   logic              irq_q;
   logic              hit_sts, hit_base, hit_pll, hit_ext, ext_accept, pd_fall;
   wire               unused_id = ^{dev_id_i[31], dev_id_i[27:24], dev_id_i[15:0]};

   clk_ctl_devdec u_dec (
      .ver_i (dev_id_i[30:28]),
      .cls_i (dev_id_i[23:16]),
      .gen_o (gen)
   );

   always_comb begin
      hit_sts    = off_i == OFF_W'(OFF_STS);
      hit_base   = off_i == OFF_W'(OFF_BASE);
      hit_pll    = off_i == OFF_W'(OFF_PLL);
      hit_ext    = off_i == OFF_W'(OFF_EXT);
      ext_accept = wr_en_i && hit_ext && (gen != DEV_OLDER);
      pd_fall    = ext_q[PLL_PD_BIT] && !wdata_i[PLL_PD_BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= BASE_RST;
         ext_q  <= (gen == DEV_OLDER) ? '0 : EXT_RST;
         irq_q  <= 1'b0;
      end else begin
         if (wr_en_i && hit_base) base_q <= wdata_i;
         if (ext_accept) begin
            ext_q <= wdata_i;
            if (pd_fall) irq_q <= 1'b1;
         end
         if (wr_en_i && hit_sts && wdata_i[IRQ_BIT]) irq_q <= 1'b0;
      end
   end

   clk_ctl_pll_rom #(
      .DATA_W  (DATA_W),
      .IDX_W   (XTAL_W),
      .TAB_OLD (PLL_OLD),
      .TAB_NEW (PLL_NEW)
   ) u_rom (
      .idx_i     (base_q[XTAL_LSB+XTAL_W-1:XTAL_LSB]),
      .use_new_i (gen == DEV_NEWER),
      .data_o    (pll_word)
   );

   clk_ctl_scale #(
      .PRI_W     (BASE_DIV_W),
      .EXT_W     (EXT_DIV_W),
      .OUT_W     (SCALE_W),
      .MULT      (SCALE_MULT),
      .RST_SCALE (RST_SCALE)
   ) u_scale (
      .clk       (clk),
      .rst_n     (rst_n),
      .use_ext_i (ext_q[SEL_EXT_BIT]),
      .pri_div_i (base_q[DIV_LSB+BASE_DIV_W-1:DIV_LSB]),
      .ext_div_i (ext_q[DIV_LSB+EXT_DIV_W-1:DIV_LSB]),
      .scale_o   (scale_o)
   );

   always_comb begin
      rdata_o = '0;
      if (hit_sts)       rdata_o[IRQ_BIT] = irq_q;
      else if (hit_base) rdata_o = base_q;
      else if (hit_pll)  rdata_o = pll_word;
      else if (hit_ext)  rdata_o = ext_q;
   end

   // R3: extended word stays zero on the older generation
   p_old_ext_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gen == DEV_OLDER) |-> (ext_q == '0));

   // R7: a power-on edge through an accepted write raises the flag
   p_pll_on_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_accept && pd_fall) |=> irq_q);

   // R7/R11: the flag rises only right after an accepted extended write
   p_flag_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(ext_accept));

   // R8: write-one clears the flag
   p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && hit_sts && wdata_i[IRQ_BIT]) |=> !irq_q);

   // R6: scale holds while both clock words hold
   p_scale_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(base_q) && $stable(ext_q)) |=> $stable(scale_o));

   // R10: unmapped offsets read zero
   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_sts || hit_base || hit_pll || hit_ext) |-> (rdata_o == '0));
endmodule

// File: tb/clk_ctl_regs_bench.sv
`timescale 1ns/1ps
module clk_ctl_regs_bench;
   localparam logic [5:0] A_STS = 6'h14, A_BASE = 6'h18, A_PLL = 6'h19, A_EXT = 6'h1C;
   localparam logic [31:0] T_OLD [16] = '{
      32'h0, 32'h0, 32'h0, 32'h0,
      32'h0000_A280, 32'h0000_A2C0, 32'h0000_A330, 32'h0000_A380,
      32'h0000_A3E0, 32'h0000_A430, 32'h0000_A4A0, 32'h0000_A500,
      32'h0000_A560, 32'h0000_A5D0, 32'h0000_A640, 32'h0000_A6A0};
   localparam logic [31:0] T_NEW [16] = '{
      32'h0000_1301, 32'h0000_1342, 32'h0000_1383, 32'h0000_13C4,
      32'h0000_1405, 32'h0000_1446, 32'h0000_1487, 32'h0000_14C8,
      32'h0000_1509, 32'h0000_154A, 32'h0000_158B, 32'h0000_15CC,
      32'h0000_160D, 32'h0000_164E, 32'h0000_168F, 32'h0000_16D0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] dev_id = '0;
   logic [5:0]  off = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [8:0]  scale;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   // bench model: gen 0 older, 1 newer, 2 neither
   int          m_gen;
   logic [31:0] m_base, m_ext;
   logic        m_irq;

   always #4 clk = ~clk;

   clk_ctl_regs u_clk_ctl_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .dev_id_i (dev_id),
      .off_i    (off),
      .wr_en_i  (wr_en),
      .wdata_i  (wdata),
      .rdata_o  (rdata),
      .scale_o  (scale)
   );

   function automatic int b_gen(input logic [31:0] id);
      if (id[30:28] == 3'd0) return 0;
      if (id[30:28] == 3'd1 && id[23:16] == 8'd0) return 0;
      if (id[30:28] == 3'd1 && id[23:16] == 8'd1) return 1;
      return 2;
   endfunction

   function automatic logic [31:0] b_scale(input logic [31:0] b, input logic [31:0] e);
      int d;
      d = e[31] ? int'(e[28:23]) : int'(b[26:23]);
      return 32'(5 * (d + 1));
   endfunction

   function automatic logic [31:0] b_read(input logic [5:0] a);
      case (a)
         A_STS:   return {25'd0, m_irq, 6'd0};
         A_BASE:  return m_base;
         A_PLL:   return (m_gen == 1) ? T_NEW[m_base[9:6]] : T_OLD[m_base[9:6]];
         A_EXT:   return m_ext;
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s dev=%h got=%h exp=%h", req, dev_id, got, exp);
      end
   endtask

   task automatic rd(input logic [5:0] a, input string req);
      @(negedge clk);
      off = a; wr_en = 1'b0;
      #1 check(req, rdata, b_read(a));
   endtask

   task automatic check_all(input string req);
      rd(A_STS, req); rd(A_BASE, req); rd(A_PLL, req); rd(A_EXT, req);
      check({req, " scale"}, 32'(scale), b_scale(m_base, m_ext));
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      off = a; wdata = d; wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
      case (a)
         A_STS:  if (d[6]) m_irq = 1'b0;
         A_BASE: m_base = d;
         A_EXT:  if (m_gen != 0) begin
                    if (m_ext[13] && !d[13]) m_irq = 1'b1;
                    m_ext = d;
                 end
         default: ;
      endcase
      @(posedge clk);  // scale follows one clock after the register
   endtask

   task automatic do_reset(input logic [31:0] id);
      @(negedge clk);
      dev_id = id; rst_n = 1'b0;
      m_gen  = b_gen(id);
      m_base = 32'h078E3AC0;
      m_ext  = (m_gen == 0) ? 32'd0 : 32'h07802810;
      m_irq  = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_dev(input logic [31:0] id);
      do_reset(id);
      check("R1 scale at reset", 32'(scale), 32'd80);
      check_all("R1/R2 reset");
      // R7 power-on edge, or R3/R11 ignored on older generation
      wr(A_EXT, 32'h0000_2000);
      check_all("R3/R4 ext write");
      wr(A_EXT, 32'h0000_0000);
      check_all("R7/R11 pll on flag");
      // R8: write-zero keeps, write-one clears
      wr(A_STS, 32'hFFFF_FFBF);
      check_all("R8 w0 keeps flag");
      wr(A_STS, 32'h0000_0040);
      check_all("R8 w1 clears flag");
      // R6 extended divider at its maximum
      wr(A_EXT, 32'h9F80_0000);
      check_all("R6 ext div max");
      wr(A_BASE, 32'h0000_03C0);
      check_all("R6/R9 base div 0 xtal 15");
      wr(A_EXT, 32'h0000_0000);
      check_all("R6 back to base div");
      // R10 unmapped and R9 read-only
      wr(6'h3F, 32'hFFFF_FFFF);
      check_all("R10 unmapped write");
      rd(6'h00, "R10 unmapped read");
      wr(A_PLL, 32'h1234_5678);
      check_all("R9 pll write ignored");
      for (int i = 0; i < 120; i++) begin
         logic [5:0]  a;
         logic [31:0] d;
         int sel;
         sel = int'($urandom % 6);
         case (sel)
            0: a = A_STS;
            1: a = A_BASE;
            2: a = A_PLL;
            3, 4: a = A_EXT;
            default: a = 6'($urandom);
         endcase
         d = $urandom;
         if ($urandom % 4 != 0) begin
            wr(a, d);
            check_all("R4/R5/R6/R7/R10 random write");
         end else begin
            rd(a, "R9/R10 random read");
         end
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      run_dev(32'h0005_0000);  // version 0, any class: older
      run_dev(32'h1000_0000);  // version 1 class 0: older
      run_dev(32'h1001_0000);  // version 1 class 1: newer
      run_dev(32'h2001_0000);  // version 2: neither
      run_dev(32'h1002_0000);  // version 1 class 2: neither
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         miscompares++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule